// File: doc/BRIEF.md
# Edge-Triggered Interrupt Controller

This block collects sixteen asynchronous event lines and turns each rising edge into a sticky pending bit. A host reads and clears the pending bits through a small synchronous register port, and uses a second register to block individual lines. A single registered interrupt request goes to the host CPU. It is raised while any pending bit is unblocked and belongs to the fixed set of lines wired through to the CPU.

The routing set is a build-time constant. Its default passes only lines 8, 9 and 10. Pending bits on the other lines can still be read and cleared, but they never raise the request. Software clears a pending bit by writing 0 to its position and leaves a bit untouched by writing 1. This lets a handler clear one line without a read-modify-write race against new edges.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset the pending register reads 0x0000, the block register reads 0x0700 and `irq_o` is 0.
- R2: A rising edge on `line_i[k]` sets pending bit k. The bit is readable at byte address 0x2 from the third rising clock edge after the input changes, and it stays set until cleared.
- R3: A write to byte address 0x2 clears each pending bit whose data bit is 0, and leaves each bit written as 1 unchanged.
- R4: The block register at byte address 0xA is written and read as a whole 16-bit word.
- R5: `irq_o` is 1 exactly one clock after (0x0700 AND NOT block AND pending) is nonzero, where a block bit of 1 disables its line. A change to the block register shows on `irq_o` on the second clock edge after the write.
- R6: Pending bits outside lines 8..10 never assert `irq_o`, even with the block register all zero.
- R7: When an edge on line k arrives in the same cycle as a write that clears bit k, bit k ends up set.
- R8: Reads change no state. Addresses other than 0x2 and 0xA read 0x0000, and writes to them change nothing.
- R9: A line held high sets its bit only once: after that bit is cleared it stays 0 until a new rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 16 | Asynchronous event lines |
| addr_i | input | 4 | Register byte address |
| wr_i | input | 1 | Write strobe, sampled on the clock edge |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Registered interrupt request to the CPU |

## Verification
The assertions assume that the synchronized lines are what define an edge. They check pending and request behaviour against the synchronizer output rather than the raw pins, so they hold no matter how the pins glitch. The bench changes lines, address, data and strobe only on falling clock edges. It holds every line pulse for several cycles, so each transition crosses the synchronizer cleanly. The coincidence case of R7 is placed by counting the synchronizer stages, so that the clearing write lands on the very edge that latches the new event.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PEND = 2'd1,
    SEL_BLK  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] async_i,
  output logic [NUM_LINES-1:0] sync_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic meta_q, stable_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= async_i[g];
        stable_q <= meta_q;
      end
    end
    assign sync_o[g] = stable_q;
  end
endmodule

// File: rtl/edge_irq_pend.sv
module edge_irq_pend #(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] sync_i,
  input  logic                 clr_en_i,
  input  logic [NUM_LINES-1:0] keep_i,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] prev_q, rise, keep, pend_q;

  assign rise = sync_i & ~prev_q;
  assign keep = clr_en_i ? keep_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= sync_i;
      // new edge wins over a coincident clear
      pend_q <= (pend_q & keep) | rise;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int unsigned          NUM_LINES = 16,
  parameter int unsigned          ADDR_W    = 4,
  parameter logic [ADDR_W-1:0]    PEND_OFS  = 'h2,
  parameter logic [ADDR_W-1:0]    BLK_OFS   = 'hA,
  parameter logic [NUM_LINES-1:0] BLK_RST   = 'h0700
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  input  logic [NUM_LINES-1:0] pend_i,
  output logic                 clr_en_o,
  output logic [NUM_LINES-1:0] blk_o,
  output logic [NUM_LINES-1:0] rdata_o
);
  reg_sel_e             sel;
  logic [NUM_LINES-1:0] blk_q;

  always_comb begin
    if (addr_i == PEND_OFS)     sel = SEL_PEND;
    else if (addr_i == BLK_OFS) sel = SEL_BLK;
    else                        sel = SEL_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     blk_q <= BLK_RST;
    else if (wr_i && sel == SEL_BLK) blk_q <= wdata_i;
  end

  always_comb begin
    unique case (sel)
      SEL_PEND: rdata_o = pend_i;
      SEL_BLK:  rdata_o = blk_q;
      default:  rdata_o = '0;
    endcase
  end

  assign clr_en_o = wr_i && (sel == SEL_PEND);
  assign blk_o    = blk_q;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int unsigned          NUM_LINES = 16,
  parameter int unsigned          ADDR_W    = 4,
  parameter logic [ADDR_W-1:0]    PEND_OFS  = 'h2,
  parameter logic [ADDR_W-1:0]    BLK_OFS   = 'hA,
  parameter logic [NUM_LINES-1:0] ROUTE     = 'h0700,
  parameter logic [NUM_LINES-1:0] BLK_RST   = 'h0700
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] rdata_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] line_sync, pend_q, blk_q;
  logic                 clr_en, irq_q;

  edge_irq_sync #(.NUM_LINES(NUM_LINES)) i_sync (
    .clk_i, .rst_ni, .async_i(line_i), .sync_o(line_sync)
  );

  edge_irq_pend #(.NUM_LINES(NUM_LINES)) i_pend (
    .clk_i, .rst_ni, .sync_i(line_sync), .clr_en_i(clr_en),
    .keep_i(wdata_i), .pend_o(pend_q)
  );

  edge_irq_regs #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .PEND_OFS(PEND_OFS),
    .BLK_OFS(BLK_OFS), .BLK_RST(BLK_RST)
  ) i_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i, .pend_i(pend_q),
    .clr_en_o(clr_en), .blk_o(blk_q), .rdata_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(ROUTE & ~blk_q & pend_q);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
  parameter int unsigned          NUM_LINES = 16,
  parameter int unsigned          ADDR_W    = 4,
  parameter logic [ADDR_W-1:0]    PEND_OFS  = 'h2,
  parameter logic [ADDR_W-1:0]    BLK_OFS   = 'hA,
  parameter logic [NUM_LINES-1:0] ROUTE     = 'h0700
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 wr_i,
  input logic [NUM_LINES-1:0] wdata_i,
  input logic                 irq_o,
  input logic [NUM_LINES-1:0] line_sync,
  input logic [NUM_LINES-1:0] pend_q,
  input logic [NUM_LINES-1:0] blk_q
);
  logic [NUM_LINES-1:0] seen_q, edge_now;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else         seen_q <= line_sync;
  end
  assign edge_now = line_sync & ~seen_q;

  // R2
  pend_only_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_q & ~$past(pend_q) & ~$past(edge_now)) == '0);

  // R3
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == PEND_OFS) |=>
      (pend_q & ~$past(wdata_i) & ~$past(edge_now)) == '0);

  // R7
  edge_not_lost_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_q & $past(edge_now)) == $past(edge_now));

  // R4
  blk_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == BLK_OFS) |=> blk_q == $past(wdata_i));

  // R8
  blk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == BLK_OFS) |=> $stable(blk_q));

  // R5
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == |(ROUTE & ~$past(blk_q) & $past(pend_q)));

  // R6
  irq_route_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ROUTE & pend_q) == '0) |=> !irq_o);
endmodule

bind edge_irq_ctrl edge_irq_chk #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .PEND_OFS(PEND_OFS),
  .BLK_OFS(BLK_OFS), .ROUTE(ROUTE)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .line_sync(line_sync),
  .pend_q(pend_q), .blk_q(blk_q)
);

// File: tb/test_edge_irq_ctrl.sv
module test_edge_irq_ctrl;
  localparam logic [3:0] A_PEND = 4'h2;
  localparam logic [3:0] A_BLK  = 4'hA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] line = '0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  edge_irq_ctrl i_edge_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .addr_i(addr),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_wr(logic [3:0] a, logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(string req, logic [3:0] a, logic [15:0] exp);
    addr = a;
    #1 check(req, rdata, exp);
  endtask

  task automatic pulse(int k);
    line[k] = 1'b1; idle(4);
    line[k] = 1'b0; idle(4);
  endtask

  task automatic t_reset;
    bus_rd("R1", A_PEND, 16'h0000);
    bus_rd("R1", A_BLK, 16'h0700);
    check("R1", 16'(irq), 16'h0);
  endtask

  task automatic t_edge;
    line[3] = 1'b1;
    idle(2);
    bus_rd("R2", A_PEND, 16'h0000);   // two edges in: not yet latched
    idle(1);
    bus_rd("R2", A_PEND, 16'h0008);   // third edge latched it
    line[3] = 1'b0; idle(4);
    bus_rd("R2", A_PEND, 16'h0008);
    check("R6", 16'(irq), 16'h0);
    line[4] = 1'b1; idle(4);
    bus_rd("R9", A_PEND, 16'h0018);
    bus_wr(A_PEND, 16'hFFEF);
    idle(4);
    bus_rd("R9", A_PEND, 16'h0008);
    line[4] = 1'b0; idle(3);
  endtask

  task automatic t_clear;
    pulse(0); pulse(1);
    bus_rd("R3", A_PEND, 16'h000B);
    bus_wr(A_PEND, 16'hFFFE);
    bus_rd("R3", A_PEND, 16'h000A);
    bus_wr(A_PEND, 16'h0000);
    bus_rd("R3", A_PEND, 16'h0000);
  endtask

  task automatic t_regs;
    bus_wr(A_BLK, 16'h5A5A);
    bus_rd("R4", A_BLK, 16'h5A5A);
    idle(3);
    bus_rd("R8", A_BLK, 16'h5A5A);
    pulse(6);
    bus_rd("R8", A_PEND, 16'h0040);
    bus_rd("R8", A_PEND, 16'h0040);
    bus_wr(4'h4, 16'h0000);
    bus_rd("R8", 4'h4, 16'h0000);
    bus_rd("R8", A_BLK, 16'h5A5A);
    bus_rd("R8", A_PEND, 16'h0040);
    bus_wr(A_PEND, 16'h0000);
    bus_wr(A_BLK, 16'h0700);
  endtask

  task automatic t_irq;
    pulse(9);
    bus_rd("R5", A_PEND, 16'h0200);
    check("R5", 16'(irq), 16'h0);
    bus_wr(A_BLK, 16'h0500);
    check("R5", 16'(irq), 16'h0);      // one edge after write
    @(negedge clk);
    check("R5", 16'(irq), 16'h1);      // second edge after write
    bus_wr(A_PEND, 16'hFDFF);
    check("R5", 16'(irq), 16'h1);
    @(negedge clk);
    check("R5", 16'(irq), 16'h0);
    bus_wr(A_BLK, 16'h0000);
    pulse(2); pulse(15); pulse(7); pulse(11);
    bus_rd("R6", A_PEND, 16'h8884);
    check("R6", 16'(irq), 16'h0);
    pulse(10);
    check("R5", 16'(irq), 16'h1);
    bus_wr(A_PEND, 16'h0000);
    idle(1);
    check("R5", 16'(irq), 16'h0);
  endtask

  task automatic t_collide;
    pulse(0);
    line[5] = 1'b1;
    idle(2);
    bus_wr(A_PEND, 16'h0000);          // lands on the latching edge
    bus_rd("R7", A_PEND, 16'h0020);
    line[5] = 1'b0; idle(3);
  endtask

  initial begin
    fork
      begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_edge();
        t_clear();
        t_regs();
        t_irq();
        t_collide();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule